// File: doc/BRIEF.md
# External Interrupt Front End

This block sits between a bank of asynchronous interrupt pins and a parent interrupt controller. Every pin is resynchronised into the clock domain. Each line then goes through its own trigger detector, which can be set to edge or level detection with either polarity. A detected event sets a sticky per-line request latch. The latched request, gated by a per-line mask, drives a dedicated active-high level output toward the parent. This holds for every trigger type, so the parent always sees level interrupts.

Software controls the block through a small 32-bit register window with single-cycle write and read strobes. Requests are retired by a write-one-to-clear register. A separate write-only register lets software raise a request directly. Level requests are latched just like edge requests, so they stay pending until software clears them. A clear aimed at a level line whose input is still active does not take effect.

Top module: `ext_irq_front`

## Requirements
- R1: Reset state: every mask bit reads 1, the polarity, trigger and source-select registers read 0, and every interrupt output is low.
- R2: An output bit is high exactly when its request latch is set and its mask bit is 0. The masked status register (offset 0x08) reads raw requests AND NOT mask.
- R3: The trigger register (offset 0x18) selects edge detection with a 1 and level detection with a 0. The polarity register (offset 0x14) selects rising edge or active-high level with a 1, and falling edge or active-low level with a 0. A qualifying pin change sets the raw request on the third rising clock edge after it.
- R4: A level request stays latched after its input goes inactive. While the level input is still active, a clear leaves the request set.
- R5: The clear register (offset 0x10) is write-one-to-clear per bit. Bits written 0 leave their requests unchanged.
- R6: Requests keep latching while a line is masked. A stale request appears on the output as soon as the line is unmasked.
- R7: When a detected event and a clear hit the same line on the same clock edge, the request ends up set.
- R8: Every output is an active-high level, for edge-triggered and falling-polarity lines alike.
- R9: Writing a 1 to a bit of the software request register (offset 0x1C) sets that line's request latch. That register, like the clear register, reads as zero.
- R10: The source-select register (offset 0x04) is plain read/write storage.
- R11: The mask register is at offset 0x00 and the raw status at offset 0x0C. Read data appears on the first clock edge after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pin | input | N_LINES | Asynchronous interrupt pins |
| reg_wr | input | 1 | Single-cycle register write strobe |
| reg_rd | input | 1 | Single-cycle register read strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | N_LINES | Write data |
| reg_rdata | output | N_LINES | Registered read data |
| irq_out | output | N_LINES | Active-high level interrupt per line to the parent |

## Verification
The bench builds the block with its defaults: 32 lines and a two-stage synchroniser. With these values the lowest and highest lines (0 and 31) are exercised, and the full-word clear and mask patterns match the register width. The three-edge pin-to-latch delay is also exact, so an edge can be placed precisely on the clock edge where a clear write lands. All four combinations of polarity and trigger mode are driven through the vector table. Among them are level lines held active across a clear.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int REG_AW = 5;
  localparam logic [REG_AW-1:0] OFS_MASK  = 5'h00;
  localparam logic [REG_AW-1:0] OFS_SRC   = 5'h04;
  localparam logic [REG_AW-1:0] OFS_MSTAT = 5'h08;
  localparam logic [REG_AW-1:0] OFS_RAW   = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_CLR   = 5'h10;
  localparam logic [REG_AW-1:0] OFS_POL   = 5'h14;
  localparam logic [REG_AW-1:0] OFS_TRIG  = 5'h18;
  localparam logic [REG_AW-1:0] OFS_SWREQ = 5'h1C;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stg [STAGES];

  genvar gs;
  generate
    for (gs = 0; gs < STAGES; gs++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[gs] <= '0;
        else if (gs == 0) stg[gs] <= async_i;
        else stg[gs] <= stg[(gs == 0) ? 0 : gs-1];
      end
    end
  endgenerate

  assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl_i,
  input  logic [WIDTH-1:0] pol_i,
  input  logic [WIDTH-1:0] edge_mode_i,
  input  logic [WIDTH-1:0] clr_i,
  input  logic [WIDTH-1:0] swset_i,
  output logic [WIDTH-1:0] req_o
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] hit;
  logic [WIDTH-1:0] req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else prev_q <= lvl_i;
  end

  genvar gl;
  generate
    for (gl = 0; gl < WIDTH; gl++) begin : g_line
      logic rise, fall, lvl_act;
      always_comb begin
        rise    = lvl_i[gl] & ~prev_q[gl];
        fall    = ~lvl_i[gl] & prev_q[gl];
        lvl_act = (lvl_i[gl] == pol_i[gl]);
        if (edge_mode_i[gl]) hit[gl] = pol_i[gl] ? rise : fall;
        else hit[gl] = lvl_act;
      end
    end
  endgenerate

  // a new event takes precedence over a clear on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else req_q <= hit | swset_i | (req_q & ~clr_i);
  end

  assign req_o = req_q;
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic [WIDTH-1:0]  raw_i,
  input  logic [WIDTH-1:0]  mstat_i,
  output logic [WIDTH-1:0]  rdata_o,
  output logic [WIDTH-1:0]  mask_o,
  output logic [WIDTH-1:0]  pol_o,
  output logic [WIDTH-1:0]  edge_mode_o,
  output logic [WIDTH-1:0]  clr_o,
  output logic [WIDTH-1:0]  swset_o
);
  logic [WIDTH-1:0] mask_q, src_q, pol_q, trig_q, rdata_q, rd_mux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      src_q  <= '0;
      pol_q  <= '0;
      trig_q <= '0;
    end else if (wr_i) begin
      case (addr_i)
        OFS_MASK: mask_q <= wdata_i;
        OFS_SRC:  src_q  <= wdata_i;
        OFS_POL:  pol_q  <= wdata_i;
        OFS_TRIG: trig_q <= wdata_i;
        default:  ;
      endcase
    end
  end

  assign clr_o   = (wr_i && addr_i == OFS_CLR)   ? wdata_i : '0;
  assign swset_o = (wr_i && addr_i == OFS_SWREQ) ? wdata_i : '0;

  always_comb begin
    case (addr_i)
      OFS_MASK:  rd_mux = mask_q;
      OFS_SRC:   rd_mux = src_q;
      OFS_MSTAT: rd_mux = mstat_i;
      OFS_RAW:   rd_mux = raw_i;
      OFS_POL:   rd_mux = pol_q;
      OFS_TRIG:  rd_mux = trig_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o     = rdata_q;
  assign mask_o      = mask_q;
  assign pol_o       = pol_q;
  assign edge_mode_o = trig_q;
endmodule

// File: rtl/ext_irq_front.sv
module ext_irq_front
  import ext_irq_pkg::*;
#(
  parameter int N_LINES     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_pin,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [N_LINES-1:0] reg_wdata,
  output logic [N_LINES-1:0] reg_rdata,
  output logic [N_LINES-1:0] irq_out
);
  logic [N_LINES-1:0] pin_sync, req_q, mask, pol, edge_mode, clr, swset, mstat;

  ext_irq_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(irq_pin), .sync_o(pin_sync)
  );

  ext_irq_detect #(.WIDTH(N_LINES)) u_detect (
    .clk(clk), .rst_n(rst_n), .lvl_i(pin_sync), .pol_i(pol),
    .edge_mode_i(edge_mode), .clr_i(clr), .swset_i(swset), .req_o(req_q)
  );

  assign mstat = req_q & ~mask;

  ext_irq_regs #(.WIDTH(N_LINES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .rd_i(reg_rd), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .raw_i(req_q), .mstat_i(mstat), .rdata_o(reg_rdata),
    .mask_o(mask), .pol_o(pol), .edge_mode_o(edge_mode), .clr_o(clr),
    .swset_o(swset)
  );

  assign irq_out = mstat;
endmodule

// File: rtl/ext_irq_front_chk.sv
module ext_irq_front_chk
  import ext_irq_pkg::*;
#(
  parameter int N_LINES = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic               reg_rd,
  input logic [REG_AW-1:0]  reg_addr,
  input logic [N_LINES-1:0] reg_wdata,
  input logic [N_LINES-1:0] reg_rdata,
  input logic [N_LINES-1:0] irq_out,
  input logic [N_LINES-1:0] req
);
  logic [N_LINES-1:0] clr_now;
  assign clr_now = (reg_wr && reg_addr == OFS_CLR) ? reg_wdata : '0;

  // R1
  out_low_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> irq_out == '0);

  // R2
  out_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & ~req) == '0);

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req) & ~req & ~$past(clr_now)) == '0);

  // R9
  sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_SWREQ) |=> ((req & $past(reg_wdata)) == $past(reg_wdata)));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
endmodule

bind ext_irq_front ext_irq_front_chk #(.N_LINES(N_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out), .req(req_q)
);

// File: tb/tb_ext_irq_front.sv
module tb_ext_irq_front;
  localparam int N = 32;
  localparam logic [4:0] A_MASK = 5'h00, A_SRC = 5'h04, A_MST = 5'h08, A_RAW = 5'h0C,
                         A_CLR = 5'h10, A_POL = 5'h14, A_TRIG = 5'h18, A_SW = 5'h1C;

  // {line[4:0], pol, edge_mode, start_level, end_level, expected_latch}
  localparam int NV = 9;
  localparam logic [9:0] VEC [NV] = '{
    {5'd0,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {5'd1,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    {5'd2,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    {5'd3,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {5'd4,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    {5'd5,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {5'd6,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {5'd31, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {5'd20, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] irq_pin = '1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata, irq_out;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ext_irq_front #(.N_LINES(N), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  // callers are at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [4:0] a, input logic [N-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [N-1:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [N-1:0] v;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq_out", irq_out, '0);
    rd(A_MASK, v); check("R1 mask", v, '1);
    rd(A_POL, v);  check("R1 polarity", v, '0);
    rd(A_TRIG, v); check("R1 trigger", v, '0);
    rd(A_SRC, v);  check("R1 source select", v, '0);
    idle(3);
    wr(A_CLR, '1);
    rd(A_RAW, v); check("R11 raw after full clear", v, '0);

    // R3 R8 vector walk
    for (int i = 0; i < NV; i++) begin
      logic [4:0] ln;
      logic p, m, s, e, x;
      {ln, p, m, s, e, x} = VEC[i];
      irq_pin = '1; irq_pin[ln] = s;
      idle(4);
      wr(A_POL, {{(N-1){1'b0}}, p} << ln);
      wr(A_TRIG, {{(N-1){1'b0}}, m} << ln);
      idle(4);
      wr(A_CLR, '1);
      irq_pin[ln] = e;
      idle(5);
      rd(A_RAW, v);
      check("R3 R4 raw latch per trigger type", v, {{(N-1){1'b0}}, x} << ln);
      wr(A_MASK, ~({{(N-1){1'b0}}, 1'b1} << ln));
      check("R8 active-high output", irq_out, {{(N-1){1'b0}}, x} << ln);
      wr(A_MASK, '1);
      irq_pin = '1;
      wr(A_POL, '0);
      wr(A_TRIG, '0);
      idle(4);
      wr(A_CLR, '1);
    end

    // R10 source select storage
    wr(A_SRC, 32'hA5C3_0F18);
    rd(A_SRC, v); check("R10 source select readback", v, 32'hA5C3_0F18);

    // R9 software request and R5 partial clear
    wr(A_SW, 32'h0000_0006);
    rd(A_RAW, v); check("R9 software set", v, 32'h0000_0006);
    rd(A_SW, v);  check("R9 software register reads zero", v, '0);
    wr(A_CLR, 32'h0000_0002);
    rd(A_RAW, v); check("R5 zero bits untouched", v, 32'h0000_0004);
    wr(A_CLR, 32'h0000_0004);

    // R6 R2 masked latching then unmask
    wr(A_SW, 32'h0000_0200);
    check("R6 masked output low", irq_out, '0);
    rd(A_MST, v); check("R2 masked status while masked", v, '0);
    wr(A_MASK, ~32'h0000_0200);
    check("R6 stale request on unmask", irq_out, 32'h0000_0200);
    rd(A_MST, v); check("R2 masked status", v, 32'h0000_0200);
    wr(A_MASK, '1);
    wr(A_CLR, '1);

    // R4 level held across clear, then latched after release
    wr(A_POL, 32'h0000_0020);
    irq_pin[5] = 1'b0;
    idle(4);
    wr(A_CLR, '1);
    irq_pin[5] = 1'b1;
    idle(4);
    wr(A_CLR, 32'h0000_0020);
    rd(A_RAW, v); check("R4 clear ignored while active", v, 32'h0000_0020);
    irq_pin[5] = 1'b0;
    idle(4);
    rd(A_RAW, v); check("R4 latched after release", v, 32'h0000_0020);
    wr(A_CLR, 32'h0000_0020);
    rd(A_RAW, v); check("R4 clear after release", v, '0);
    irq_pin = '1;
    wr(A_POL, '0);
    idle(4);
    wr(A_CLR, '1);

    // R7 edge and clear on the same rising edge
    irq_pin[8] = 1'b0;
    wr(A_POL, 32'h0000_0100);
    wr(A_TRIG, 32'h0000_0100);
    idle(4);
    wr(A_CLR, '1);
    idle(2);
    irq_pin[8] = 1'b1;
    idle(2);
    wr(A_CLR, 32'h0000_0100);
    rd(A_RAW, v); check("R7 set wins over clear", v, 32'h0000_0100);
    wr(A_CLR, '1);
    rd(A_RAW, v); check("R5 later clear retires edge", v, '0);

    done = 1'b1;
    finish_run();
  end
endmodule